// File: doc/BRIEF.md
# Register-indexed predication lookup table

This block keeps a small programmable list of predication bindings and turns it into per-register state that instruction decode can query directly. Each of the 16 list entries names an architectural register, integer or floating-point, together with the register that holds its predicate mask and two modifiers: invert the mask before use, and zero-fill the elements that the mask disables. The list is written key-value style, one entry at a time. After every write the block regenerates two 32-slot reverse tables, one per register class, so that decode can look up a destination register in a single cycle.

A second stage takes the predicate mask once it has been fetched elsewhere and combines it with the most recent lookup result. It produces a per-element write enable and a per-element zero-write strobe for up to 16 elements. Reading the predicate register file and executing the operation are done by the surrounding pipeline.

Top module: `pred_lut`

## Requirements
- R1: After reset no register of either class is predicated, `lk_en` is 0, `cfg_err` is 0, and `elem_we` and `elem_zero` are all zeros.
- R2: A lookup request on `lk_req` presents `lk_en`, `lk_pidx`, `lk_inv` and `lk_zero` for the requested register at the clock edge that samples the request. Without a request these outputs hold their value.
- R3: The class bit (entry bit 10, 1 = floating-point) selects the reverse table an entry fills. The same register number in the other class stays unaffected.
- R4: When two valid entries name the same register and class, the entry with the higher index supplies the lookup result, regardless of the order in which the entries were written.
- R5: Every accepted write rebuilds both reverse tables from the whole entry list. A register that is no longer named by any entry reads back as disabled, and a lower entry that still names it becomes visible again.
- R6: A write whose bank bit (entry bit 13) is 1 leaves the entry list unchanged and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R7: With `lk_en` 0 the register is unpredicated: an applied mask gives `elem_we` all ones and `elem_zero` all zeros, one edge after `mask_valid`.
- R8: With `lk_en` 1 and the invert flag (entry bit 11) set, the effective mask is the bitwise inverse of `mask_bits`. With the invert flag clear it equals `mask_bits`. `elem_we` equals the effective mask.
- R9: With the zeroing flag (entry bit 12) set, `elem_zero` is the inverse of the effective mask. With the flag clear, `elem_zero` is all zeros. `elem_we` and `elem_zero` never share a set bit.
- R10: An entry places its predicate register index in bits 4..0 and its target register in bits 9..5. `lk_pidx` returns bits 4..0 of the winning entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write one entry of the list |
| cfg_idx | input | 4 | Entry number to write |
| cfg_data | input | 14 | Entry contents (bank, zero, inv, class, target, predicate) |
| lk_req | input | 1 | Lookup request |
| lk_reg | input | 5 | Destination register to look up |
| lk_fp | input | 1 | Class of the looked-up register, 1 = floating-point |
| lk_en | output | 1 | Register is predicated |
| lk_pidx | output | 5 | Predicate register index |
| lk_inv | output | 1 | Invert modifier |
| lk_zero | output | 1 | Zeroing modifier |
| mask_valid | input | 1 | Fetched mask present |
| mask_bits | input | 16 | Fetched predicate mask, bit i for element i |
| elem_we | output | 16 | Per-element write enable |
| elem_zero | output | 16 | Per-element zero-write strobe |
| cfg_err | output | 1 | Sticky reserved-bank write error |

## Verification
An entry write changes the reverse tables at the edge that samples it, so a lookup driven in the next cycle already sees the new mapping, and `cfg_err` is updated at that same edge. Lookup outputs are due one edge after `lk_req`, and element strobes one edge after `mask_valid`, using the lookup result visible when the mask was driven. The bench drives every stimulus on the falling edge for one cycle and reads the results on the following falling edge, exactly one rising edge later.

// File: rtl/pred_lut_pkg.sv
package pred_lut_pkg;
    parameter int ENTRIES = 16;
    parameter int REG_W   = 5;
    parameter int ELEMS   = 16;
    localparam int NREGS  = 1 << REG_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int ENT_W  = 4 + 2 * REG_W;

    // field order defines the entry encoding: bank is the MSB
    typedef struct packed {
        logic             bank;
        logic             zero;
        logic             inv;
        logic             fp;
        logic [REG_W-1:0] reg_idx;
        logic [REG_W-1:0] pred_idx;
    } entry_t;

    typedef struct packed {
        logic             en;
        logic             zero;
        logic             inv;
        logic             bank;
        logic [REG_W-1:0] pidx;
    } slot_t;
endpackage

// File: rtl/pred_lut_table.sv
module pred_lut_table
    import pred_lut_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [ENT_W-1:0]       cfg_data,
    output slot_t [NREGS-1:0]      int_tab,
    output slot_t [NREGS-1:0]      fp_tab,
    output logic                   cfg_err
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic   [ENTRIES-1:0] vld;
        slot_t  [NREGS-1:0]   itab;
        slot_t  [NREGS-1:0]   ftab;
        logic                 err;
    } state_t;

    state_t s_d, s_q;
    entry_t wr_d;

    always_comb begin
        s_d  = s_q;
        wr_d = entry_t'(cfg_data);
        if (cfg_we) begin
            if (wr_d.bank) begin
                s_d.err = 1'b1;
            end else begin
                s_d.ent[cfg_idx] = wr_d;
                s_d.vld[cfg_idx] = 1'b1;
            end
        end
        // full rebuild; ascending order lets the higher entry win
        s_d.itab = '0;
        s_d.ftab = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (s_d.vld[e]) begin
                if (s_d.ent[e].fp) begin
                    s_d.ftab[s_d.ent[e].reg_idx] = '{en: 1'b1, zero: s_d.ent[e].zero,
                        inv: s_d.ent[e].inv, bank: s_d.ent[e].bank, pidx: s_d.ent[e].pred_idx};
                end else begin
                    s_d.itab[s_d.ent[e].reg_idx] = '{en: 1'b1, zero: s_d.ent[e].zero,
                        inv: s_d.ent[e].inv, bank: s_d.ent[e].bank, pidx: s_d.ent[e].pred_idx};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_tab = s_q.itab;
    assign fp_tab  = s_q.ftab;
    assign cfg_err = s_q.err;
endmodule

// File: rtl/pred_lut_lookup.sv
module pred_lut_lookup
    import pred_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t [NREGS-1:0] int_tab,
    input  slot_t [NREGS-1:0] fp_tab,
    input  logic              lk_req,
    input  logic [REG_W-1:0]  lk_reg,
    input  logic              lk_fp,
    output logic              lk_en,
    output logic [REG_W-1:0]  lk_pidx,
    output logic              lk_inv,
    output logic              lk_zero
);
    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] pidx;
        logic             inv;
        logic             zero;
    } state_t;

    state_t s_d, s_q;
    slot_t  sel_d;

    always_comb begin
        s_d   = s_q;
        sel_d = lk_fp ? fp_tab[lk_reg] : int_tab[lk_reg];
        if (lk_req) begin
            s_d.en   = sel_d.en;
            s_d.pidx = sel_d.pidx;
            s_d.inv  = sel_d.inv;
            s_d.zero = sel_d.zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lk_en   = s_q.en;
    assign lk_pidx = s_q.pidx;
    assign lk_inv  = s_q.inv;
    assign lk_zero = s_q.zero;
endmodule

// File: rtl/pred_lut_apply.sv
module pred_lut_apply
    import pred_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pr_en,
    input  logic             pr_inv,
    input  logic             pr_zero,
    input  logic             mask_valid,
    input  logic [ELEMS-1:0] mask_bits,
    output logic [ELEMS-1:0] elem_we,
    output logic [ELEMS-1:0] elem_zero
);
    typedef struct packed {
        logic [ELEMS-1:0] we;
        logic [ELEMS-1:0] zr;
    } state_t;

    state_t           s_d, s_q;
    logic [ELEMS-1:0] eff_d;

    always_comb begin
        s_d   = s_q;
        eff_d = !pr_en ? '1 : (pr_inv ? ~mask_bits : mask_bits);
        if (mask_valid) begin
            s_d.we = eff_d;
            s_d.zr = (pr_en && pr_zero) ? ~eff_d : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign elem_we   = s_q.we;
    assign elem_zero = s_q.zr;
endmodule

// File: rtl/pred_lut.sv
module pred_lut
    import pred_lut_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_idx,
    input  logic [13:0]      cfg_data,
    input  logic             lk_req,
    input  logic [4:0]       lk_reg,
    input  logic             lk_fp,
    output logic             lk_en,
    output logic [4:0]       lk_pidx,
    output logic             lk_inv,
    output logic             lk_zero,
    input  logic             mask_valid,
    input  logic [15:0]      mask_bits,
    output logic [15:0]      elem_we,
    output logic [15:0]      elem_zero,
    output logic             cfg_err
);
    slot_t [NREGS-1:0] int_tab;
    slot_t [NREGS-1:0] fp_tab;

    pred_lut_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .int_tab  (int_tab),
        .fp_tab   (fp_tab),
        .cfg_err  (cfg_err)
    );

    pred_lut_lookup u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_tab (int_tab),
        .fp_tab  (fp_tab),
        .lk_req  (lk_req),
        .lk_reg  (lk_reg),
        .lk_fp   (lk_fp),
        .lk_en   (lk_en),
        .lk_pidx (lk_pidx),
        .lk_inv  (lk_inv),
        .lk_zero (lk_zero)
    );

    pred_lut_apply u_apply (
        .clk        (clk),
        .rst_n      (rst_n),
        .pr_en      (lk_en),
        .pr_inv     (lk_inv),
        .pr_zero    (lk_zero),
        .mask_valid (mask_valid),
        .mask_bits  (mask_bits),
        .elem_we    (elem_we),
        .elem_zero  (elem_zero)
    );
endmodule

// File: rtl/pred_lut_chk.sv
module pred_lut_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [13:0] cfg_data,
    input logic        lk_req,
    input logic        lk_en,
    input logic [4:0]  lk_pidx,
    input logic        lk_inv,
    input logic        lk_zero,
    input logic        mask_valid,
    input logic [15:0] mask_bits,
    input logic [15:0] elem_we,
    input logic [15:0] elem_zero,
    input logic        cfg_err
);
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_bank_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_data[13]) |=> cfg_err);

    assert_lookup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> $stable({lk_en, lk_pidx, lk_inv, lk_zero}));

    assert_unpredicated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !lk_en) |=> (elem_we == 16'hFFFF && elem_zero == 16'h0000));

    assert_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && lk_en) |=>
            (elem_we == ($past(lk_inv) ? ~$past(mask_bits) : $past(mask_bits))));

    assert_no_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !lk_zero) |=> (elem_zero == 16'h0000));

    assert_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_we & elem_zero) == 16'h0000);
endmodule

bind pred_lut pred_lut_chk u_chk (.*);

// File: tb/pred_lut_bench.sv
module pred_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [13:0] cfg_data = '0;
    logic        lk_req = 1'b0;
    logic [4:0]  lk_reg = '0;
    logic        lk_fp = 1'b0;
    logic        lk_en;
    logic [4:0]  lk_pidx;
    logic        lk_inv;
    logic        lk_zero;
    logic        mask_valid = 1'b0;
    logic [15:0] mask_bits = '0;
    logic [15:0] elem_we;
    logic [15:0] elem_zero;
    logic        cfg_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pred_lut u_pred_lut (.*);

    function automatic logic [13:0] mk(input bit bank, input bit zero, input bit inv,
                                       input bit fp, input int rg, input int pr);
        return {bank, zero, inv, fp, 5'(rg), 5'(pr)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [13:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input int rg, input bit fp);
        @(negedge clk);
        lk_req = 1'b1; lk_reg = 5'(rg); lk_fp = fp;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic expect_look(input string tag, input int rg, input bit fp, input bit en,
                               input int pidx, input bit inv, input bit zero);
        look(rg, fp);
        chk({tag, " en"}, 32'(lk_en), 32'(en));
        if (en) begin
            chk({tag, " pidx"}, 32'(lk_pidx), 32'(pidx));
            chk({tag, " inv"}, 32'(lk_inv), 32'(inv));
            chk({tag, " zero"}, 32'(lk_zero), 32'(zero));
        end
    endtask

    task automatic apply(input logic [15:0] m);
        @(negedge clk);
        mask_valid = 1'b1; mask_bits = m;
        @(negedge clk);
        mask_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 lk_en", 32'(lk_en), 0);
        chk("R1 cfg_err", 32'(cfg_err), 0);
        chk("R1 elem_we", 32'(elem_we), 0);
        chk("R1 elem_zero", 32'(elem_zero), 0);
        expect_look("R1 int0", 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        expect_look("R1 fp0", 0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_basic();
        wr(0, mk(0, 0, 0, 0, 7, 3));
        expect_look("R2 R10 int7", 7, 1'b0, 1'b1, 3, 1'b0, 1'b0);
        expect_look("R3 fp7 unset", 7, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 hold pidx", 32'(lk_pidx), 32'd0);
        chk("R2 hold en", 32'(lk_en), 0);
    endtask

    task automatic t_class();
        wr(1, mk(0, 0, 1, 1, 7, 9));
        expect_look("R3 fp7", 7, 1'b1, 1'b1, 9, 1'b1, 1'b0);
        expect_look("R3 int7 kept", 7, 1'b0, 1'b1, 3, 1'b0, 1'b0);
    endtask

    task automatic t_dup();
        wr(5, mk(0, 1, 0, 0, 7, 12));
        expect_look("R4 high wins", 7, 1'b0, 1'b1, 12, 1'b0, 1'b1);
        wr(2, mk(0, 0, 0, 0, 7, 20));
        expect_look("R4 low later", 7, 1'b0, 1'b1, 12, 1'b0, 1'b1);
    endtask

    task automatic t_rebuild();
        wr(5, mk(0, 1, 0, 0, 8, 1));
        expect_look("R5 int8 new", 8, 1'b0, 1'b1, 1, 1'b0, 1'b1);
        expect_look("R5 int7 from entry2", 7, 1'b0, 1'b1, 20, 1'b0, 1'b0);
        wr(2, mk(0, 0, 0, 0, 9, 4));
        wr(0, mk(0, 0, 0, 0, 10, 6));
        expect_look("R5 int7 released", 7, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        expect_look("R5 int10", 10, 1'b0, 1'b1, 6, 1'b0, 1'b0);
    endtask

    task automatic t_bank();
        chk("R6 err before", 32'(cfg_err), 0);
        wr(1, mk(1, 0, 0, 0, 30, 2));
        chk("R6 err set", 32'(cfg_err), 1);
        expect_look("R6 entry1 kept", 7, 1'b1, 1'b1, 9, 1'b1, 1'b0);
        expect_look("R6 int30 unset", 30, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        wr(4, mk(0, 0, 0, 0, 11, 2));
        repeat (4) @(negedge clk);
        chk("R6 err sticky", 32'(cfg_err), 1);
    endtask

    task automatic t_apply();
        look(3, 1'b0);
        apply(16'h00F0);
        chk("R7 we", 32'(elem_we), 32'hFFFF);
        chk("R7 zero", 32'(elem_zero), 0);
        look(7, 1'b1);
        apply(16'h00F0);
        chk("R8 inv we", 32'(elem_we), 32'hFF0F);
        chk("R9 nozero", 32'(elem_zero), 0);
        look(8, 1'b0);
        apply(16'h1234);
        chk("R8 plain we", 32'(elem_we), 32'h1234);
        chk("R9 zero fill", 32'(elem_zero), 32'hEDCB);
        wr(3, mk(0, 1, 1, 0, 12, 2));
        look(12, 1'b0);
        apply(16'h00FF);
        chk("R8 inv+zero we", 32'(elem_we), 32'hFF00);
        chk("R9 inv+zero zero", 32'(elem_zero), 32'h00FF);
        repeat (2) @(negedge clk);
        chk("R9 hold we", 32'(elem_we), 32'hFF00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_class();
        t_dup();
        t_rebuild();
        t_bank();
        t_apply();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule